// File: doc/BRIEF.md
# Reduced-pin Ethernet transmit bridge

This block sits between a 10/100 Ethernet MAC that speaks the four-bit media independent interface and a PHY that takes the two-bit reduced interface. The whole block runs on the single 50 MHz reference clock. It makes the MAC's transmit clock from that reference clock. It takes one nibble from the MAC per transmit clock period and sends it to the PHY as two dibits.

The line rate is set by the parameter `FAST_MODE`. A value of 1 selects 100 Mb/s and 0 selects 10 Mb/s. The rate is never detected at run time. At the slow rate every dibit is repeated for `SLOW_REPEAT` reference clocks, which is 10 by default. The reduced interface has no transmit error wire, so the block marks a nibble that carries a MAC error by putting a fixed code on the line. The block also drives the MAC collision input from its own transmit activity and from the receive carrier indication.

Top module: `mii_rmii_tx_bridge`

## Requirements
- R1: `mac_tx_clk` has a period of 2 reference clocks in fast mode and 2×`SLOW_REPEAT` in slow mode. It is high for the first half of each period and low for the second half.
- R2: The MAC inputs are captured at the reference edge that ends a `mac_tx_clk` period, which is the edge at which `mac_tx_clk` rises again. Values that the MAC changes in the half cycle after a rising edge are therefore taken.
- R3: The first dibit of a captured nibble carries bits [1:0]. It appears on `phy_txd` in the reference cycle that follows the capture edge.
- R4: Each dibit holds for 1 reference clock in fast mode and for `SLOW_REPEAT` reference clocks in slow mode. The second dibit carries bits [3:2] and fills the rest of the nibble period.
- R5: `phy_tx_en` equals the captured MAC enable for the whole nibble period. It changes only at nibble boundaries.
- R6: While `phy_tx_en` is low, `phy_txd` is 2'b00, whatever `mac_txd` and `mac_tx_er` carry.
- R7: When a captured nibble has both enable and error set, both of its dibits are 2'b01 and the data bits are ignored.
- R8: `mac_col` is high exactly when `phy_tx_en` and `rx_carrier` are both high.
- R9: During reset, `phy_tx_en`, `phy_txd` and `mac_col` are low and `mac_tx_clk` is high. The first full clock period starts after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_er | input | 1 | MAC transmit error |
| mac_txd | input | 4 | MAC transmit nibble |
| rx_carrier | input | 1 | Receive carrier sense from the receive path |
| mac_tx_clk | output | 1 | Generated MAC transmit clock |
| mac_col | output | 1 | Collision indication to the MAC |
| phy_txd | output | 2 | Dibit to the PHY |
| phy_tx_en | output | 1 | Transmit enable to the PHY |

## Verification
The assertions watch the cycle-level structure on every cycle. The clock edges must fall on the capture and mid-nibble strobes. The line may change only at dibit boundaries and the enable only at nibble boundaries. An idle line must carry zeros, an errored nibble must put the error code out, and collision must imply transmit activity. The bench's scenarios show what the assertions cannot: that the dibit values are the right halves of the nibble the MAC drove, in the right order, for the right number of cycles at both rates. They also show a single-nibble frame, a burst of errored nibbles, back-to-back frames, and idle data that is ignored.

// File: rtl/mrtx_pkg.sv
package mrtx_pkg;

  // One nibble as seen on the MAC side at the capture point
  typedef struct packed {
    logic       en;
    logic       er;
    logic [3:0] d;
  } mac_nib_t;

  localparam logic [1:0] LINE_IDLE = 2'b00;
  localparam logic [1:0] LINE_ERR  = 2'b01;

  // Dibit placed on the line for one half of a nibble (upper = bits [3:2])
  function automatic logic [1:0] line_dibit(mac_nib_t n, logic upper);
    logic [1:0] r;
    if (!n.en)      r = LINE_IDLE;
    else if (n.er)  r = LINE_ERR;
    else if (upper) r = n.d[3:2];
    else            r = n.d[1:0];
    return r;
  endfunction

  // Reference clocks per dibit for a given rate selection
  function automatic int unsigned dibit_cycles(bit fast, int unsigned slow_rep);
    return fast ? 1 : slow_rep;
  endfunction

endpackage

// File: rtl/mrtx_phase.sv
module mrtx_phase #(
  parameter int unsigned DIB_LEN = 1
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic mac_tx_clk,
  output logic sample_stb,
  output logic mid_stb
);
  localparam int unsigned NIB_LEN = 2 * DIB_LEN;
  localparam int unsigned PW      = (NIB_LEN > 1) ? $clog2(NIB_LEN) : 1;
  localparam logic [PW-1:0] NIB_LAST = PW'(NIB_LEN - 1);
  localparam logic [PW-1:0] DIB_LAST = PW'(DIB_LEN - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge ref_clk) begin
    if (!rst_n)             ph <= '0;
    else if (ph == NIB_LAST) ph <= '0;
    else                    ph <= ph + 1'b1;
  end

  assign mac_tx_clk = (ph <= DIB_LAST);
  assign sample_stb = (ph == NIB_LAST);
  assign mid_stb    = (ph == DIB_LAST);

  // R1: clock edges line up with the nibble and dibit strobes
  a_r1_rise_on_capture: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(mac_tx_clk) |-> $past(sample_stb));
  a_r1_fall_on_mid: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(mac_tx_clk) |-> $past(mid_stb));
  a_r4_strobes_apart: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0({sample_stb, mid_stb}));

endmodule

// File: rtl/mrtx_serializer.sv
module mrtx_serializer
  import mrtx_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       sample_stb,
  input  logic       mid_stb,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  input  logic [3:0] mac_txd,
  output logic [1:0] phy_txd,
  output logic       phy_tx_en
);
  mac_nib_t cur_nib;
  mac_nib_t held_nib;

  assign cur_nib = '{en: mac_tx_en, er: mac_tx_er, d: mac_txd};

  always_ff @(posedge ref_clk) begin
    if (!rst_n) begin
      held_nib  <= '0;
      phy_txd   <= LINE_IDLE;
      phy_tx_en <= 1'b0;
    end else if (sample_stb) begin
      held_nib  <= cur_nib;
      phy_tx_en <= cur_nib.en;
      phy_txd   <= line_dibit(cur_nib, 1'b0);
    end else if (mid_stb) begin
      phy_txd   <= line_dibit(held_nib, 1'b1);
    end
  end

  // R6: idle line carries zeros
  a_r6_idle_zero: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !phy_tx_en |-> (phy_txd == LINE_IDLE));
  // R5: enable moves only at a nibble boundary
  a_r5_en_on_boundary: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (phy_tx_en != $past(phy_tx_en)) |-> $past(sample_stb));
  // R4: line data moves only at a dibit boundary
  a_r4_hold_dibit: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(phy_txd) |-> $past(sample_stb || mid_stb));
  // R7: errored nibble shows the error code
  a_r7_error_code: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(sample_stb && mac_tx_en && mac_tx_er) |-> (phy_txd == LINE_ERR));

endmodule

// File: rtl/mrtx_collision.sv
module mrtx_collision (
  input  logic tx_active,
  input  logic rx_carrier,
  output logic mac_col
);
  assign mac_col = tx_active & rx_carrier;
endmodule

// File: rtl/mii_rmii_tx_bridge.sv
module mii_rmii_tx_bridge
  import mrtx_pkg::*;
#(
  parameter bit          FAST_MODE   = 1'b1,
  parameter int unsigned SLOW_REPEAT = 10
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       mac_tx_en,
  input  logic       mac_tx_er,
  input  logic [3:0] mac_txd,
  input  logic       rx_carrier,
  output logic       mac_tx_clk,
  output logic       mac_col,
  output logic [1:0] phy_txd,
  output logic       phy_tx_en
);
  localparam int unsigned DIB_LEN = dibit_cycles(FAST_MODE, SLOW_REPEAT);

  logic sample_stb;
  logic mid_stb;

  mrtx_phase #(.DIB_LEN(DIB_LEN)) u_phase (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .mac_tx_clk (mac_tx_clk),
    .sample_stb (sample_stb),
    .mid_stb    (mid_stb)
  );

  mrtx_serializer u_ser (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .mid_stb    (mid_stb),
    .mac_tx_en  (mac_tx_en),
    .mac_tx_er  (mac_tx_er),
    .mac_txd    (mac_txd),
    .phy_txd    (phy_txd),
    .phy_tx_en  (phy_tx_en)
  );

  mrtx_collision u_col (
    .tx_active  (phy_tx_en),
    .rx_carrier (rx_carrier),
    .mac_col    (mac_col)
  );

  // R8: collision only while transmitting
  a_r8_col_needs_tx: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mac_col |-> phy_tx_en);

endmodule

// File: tb/mii_rmii_tx_bridge_tb.sv
module mrtx_tb_lane #(
  parameter int unsigned DLEN = 1,
  parameter int unsigned SEED = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_clk,
  input  logic [1:0] txd,
  input  logic       tx_en,
  input  logic       col,
  input  logic       carrier,
  output logic       mac_en,
  output logic       mac_er,
  output logic [3:0] mac_d,
  output int         n_chk,
  output int         n_bad
);
  typedef struct packed { logic en; logic er; logic [3:0] d; } nib_t;

  function automatic logic [1:0] want_dibit(nib_t n, bit second);
    logic [3:0] sh;
    sh = second ? (n.d >> 2) : n.d;
    if (!n.en) return 2'b00;
    if (n.er)  return 2'b01;
    return sh[1:0];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s lane%0d: actual %0d expected %0d at %0t", tag, DLEN, act, exp, $time);
    end
  endtask

  initial begin
    nib_t cur, active;
    int k, per, gap, len, fidx;
    bit seen, prev;
    logic [1:0] ew;
    string tag;
    n_chk = 0; n_bad = 0;
    mac_en = 0; mac_er = 0; mac_d = 0;
    cur = '0; active = '0;
    k = 0; per = 0; gap = 3; len = 1; fidx = 0; seen = 0; prev = 1;
    void'($urandom(SEED));
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev = tx_clk; k = 0; per = 0; active = '0; cur = '0;
        continue;
      end
      per++;
      if (tx_clk && !prev) begin
        if (seen) chk(per == 2*DLEN, "R1 clock period", per, 2*DLEN);
        seen = 1; per = 0; active = cur; k = 0;
        cur.d  = 4'($urandom);
        cur.er = ($urandom % 3 == 0);
        if (gap > 0) begin
          cur.en = 0; gap--;
        end else begin
          cur.en = 1;
          cur.er = (fidx == 1) || ($urandom % 20 == 0);
          len--;
          if (len == 0) begin
            fidx++;
            gap = (fidx == 1) ? 2 : int'($urandom % 4);
            len = (fidx == 1) ? 3 : 1 + int'($urandom % 10);
          end
        end
        mac_en = cur.en; mac_er = cur.er; mac_d = cur.d;
      end
      prev = tx_clk;
      if (k < 2*DLEN) begin
        ew = want_dibit(active, k >= DLEN);
        if (!active.en)     tag = "R6 idle dibit";
        else if (active.er) tag = "R7 error dibit";
        else if (k < DLEN)  tag = "R2 R3 low dibit";
        else                tag = "R4 high dibit";
        chk(txd == ew, tag, txd, ew);
        chk(tx_en == active.en, "R5 phy enable", tx_en, active.en);
      end
      chk(col == (tx_en & carrier), "R8 collision", col, tx_en & carrier);
      k++;
    end
  end
endmodule

module mii_rmii_tx_bridge_tb;
  localparam int CLK_PERIOD = 20;
  localparam int SLOW = 10;
  localparam int RUN_CYCLES = 8000;

  logic ref_clk = 0;
  logic rst_n = 0;
  logic carrier = 0;

  logic       f_en, f_er, s_en, s_er;
  logic [3:0] f_d, s_d;
  logic       f_clk, f_col, f_txen, s_clk, s_col, s_txen;
  logic [1:0] f_txd, s_txd;
  int f_chk, f_bad, s_chk, s_bad;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  mii_rmii_tx_bridge #(.FAST_MODE(1'b1), .SLOW_REPEAT(SLOW)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .mac_tx_en(f_en), .mac_tx_er(f_er),
    .mac_txd(f_d), .rx_carrier(carrier), .mac_tx_clk(f_clk), .mac_col(f_col),
    .phy_txd(f_txd), .phy_tx_en(f_txen));

  mii_rmii_tx_bridge #(.FAST_MODE(1'b0), .SLOW_REPEAT(SLOW)) u_dut_slow (
    .ref_clk(ref_clk), .rst_n(rst_n), .mac_tx_en(s_en), .mac_tx_er(s_er),
    .mac_txd(s_d), .rx_carrier(carrier), .mac_tx_clk(s_clk), .mac_col(s_col),
    .phy_txd(s_txd), .phy_tx_en(s_txen));

  mrtx_tb_lane #(.DLEN(1), .SEED(11)) u_lane_fast (
    .clk(ref_clk), .rst_n(rst_n), .tx_clk(f_clk), .txd(f_txd), .tx_en(f_txen),
    .col(f_col), .carrier(carrier), .mac_en(f_en), .mac_er(f_er), .mac_d(f_d),
    .n_chk(f_chk), .n_bad(f_bad));

  mrtx_tb_lane #(.DLEN(SLOW), .SEED(29)) u_lane_slow (
    .clk(ref_clk), .rst_n(rst_n), .tx_clk(s_clk), .txd(s_txd), .tx_en(s_txen),
    .col(s_col), .carrier(carrier), .mac_en(s_en), .mac_er(s_er), .mac_d(s_d),
    .n_chk(s_chk), .n_bad(s_bad));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==",
               n_chk + f_chk + s_chk, n_bad + f_bad + s_bad);
      $finish;
    end
  endtask

  // rx carrier: random bursts, changed a quarter period after the active edge
  initial begin
    void'($urandom(7));
    forever begin
      @(posedge ref_clk);
      #(CLK_PERIOD/4);
      if ($urandom % 8 == 0) carrier = ~carrier;
    end
  end

  initial begin
    repeat (4) @(negedge ref_clk);
    // R9: reset state on both instances
    chk(f_txen == 0 && f_txd == 0, "R9 fast reset line", {f_txen, f_txd}, 0);
    chk(s_txen == 0 && s_txd == 0, "R9 slow reset line", {s_txen, s_txd}, 0);
    chk(f_clk == 1 && s_clk == 1, "R9 reset clock high", {f_clk, s_clk}, 3);
    chk(f_col == 0 && s_col == 0, "R9 reset collision", {f_col, s_col}, 0);
    @(posedge ref_clk); #(CLK_PERIOD/4);
    rst_n = 1;
    repeat (RUN_CYCLES) @(negedge ref_clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule